// File: doc/BRIEF.md
# VLAN Egress Port Mask Filter

This block sits in the forwarding path of an 8-port switch, after address lookup has chosen candidate destinations. Each request carries the ingress port index, a candidate destination bitmap and a frame class flag (unicast, or multicast/broadcast). One cycle later the block returns the destination bitmap after VLAN membership filtering. The caller drops the frame when that bitmap is empty.

Every ingress port has its own visibility mask. The masks need not be symmetric: one port may see another that cannot see it back. Multicast and broadcast frames are always limited by the mask of their ingress port. Unicast frames are limited by the mask only when a global enforcement flag is set. The masks and the flag are written through a simple write-only configuration port. The block always removes the ingress port from the result.

Top module: `vlan_egress_filter`

## Requirements
- R1: After reset, rsp_valid_o is 0, rsp_dest_o is 0, every port mask is 0xFF and enforcement is clear.
- R2: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i=1. In any cycle with rsp_valid_o=0, rsp_dest_o is 0.
- R3: With req_mcast_i=1, the result is req_dest_i AND the mask of ingress port req_port_i, with the ingress bit cleared.
- R4: With req_mcast_i=0 and enforcement set, the result is masked the same way as in R3.
- R5: With req_mcast_i=0 and enforcement clear, the result is req_dest_i with only the ingress bit cleared.
- R6: Bit req_port_i of the result is always 0.
- R7: A result of all zeros is still reported with rsp_valid_o=1.
- R8: A write with cfg_mask_we_i=1 replaces only the mask of port cfg_port_i. Masks of the other ports keep their values, so masks may be asymmetric.
- R9: A configuration write in the same cycle as a request does not affect that request. It applies from the next request on.
- R10: Mask bit n (bit 0 = port index 0) allows egress to port index n. Port indices are 0-based, and result bit n stands for port index n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_we_i | input | 1 | Write strobe for one port mask |
| cfg_port_i | input | 3 | Port index whose mask is written |
| cfg_mask_i | input | 8 | New mask value |
| cfg_enf_we_i | input | 1 | Write strobe for the enforcement flag |
| cfg_enf_i | input | 1 | New enforcement value (1 = unicast obeys masks) |
| req_valid_i | input | 1 | Request strobe |
| req_port_i | input | 3 | Ingress port index |
| req_dest_i | input | 8 | Candidate destination bitmap |
| req_mcast_i | input | 1 | 1 = multicast/broadcast, 0 = unicast |
| rsp_valid_o | output | 1 | Result strobe, one cycle after the request |
| rsp_dest_o | output | 8 | Filtered destination bitmap |

## Verification
The hardest case to reach is a configuration write that lands in the same cycle as a request from the port being rewritten. Only then does the ordering between the mask read and the mask update show at the outputs. The bench drives both strobes on the same falling edge, with a new mask that differs from the old one on the requested bits. It checks that the request sees the old mask and the following request sees the new one. Asymmetric masks, with a hub port that sees all ports and leaf ports that see only the hub, are walked under both enforcement settings.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;
  localparam int unsigned NUM_PORTS = 8;
  localparam int unsigned PORT_W    = $clog2(NUM_PORTS);

  typedef logic [NUM_PORTS-1:0] port_map_t;
  typedef logic [PORT_W-1:0]    port_idx_t;
endpackage

// File: rtl/vlan_mask_store.sv
module vlan_mask_store #(
  parameter int unsigned NUM_PORTS = vlan_filt_pkg::NUM_PORTS,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                mask_we_i,
  input  logic [PORT_W-1:0]                   mask_port_i,
  input  logic [NUM_PORTS-1:0]                mask_i,
  input  logic                                enf_we_i,
  input  logic                                enf_i,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks_o,
  output logic                                enf_o
);
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks_q;
  logic                                enf_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        masks_q[p] <= '1;
      end else if (mask_we_i && (mask_port_i == PORT_W'(p))) begin
        masks_q[p] <= mask_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enf_q <= 1'b0;
    end else if (enf_we_i) begin
      enf_q <= enf_i;
    end
  end

  assign masks_o = masks_q;
  assign enf_o   = enf_q;
endmodule

// File: rtl/vlan_mask_apply.sv
module vlan_mask_apply #(
  parameter int unsigned NUM_PORTS = vlan_filt_pkg::NUM_PORTS,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks_i,
  input  logic                                enf_i,
  input  logic [PORT_W-1:0]                   port_i,
  input  logic [NUM_PORTS-1:0]                dest_i,
  input  logic                                mcast_i,
  output logic [NUM_PORTS-1:0]                sel_mask_o,
  output logic [NUM_PORTS-1:0]                dest_o
);
  logic [NUM_PORTS-1:0] allow;
  logic [NUM_PORTS-1:0] self_bit;

  always_comb begin
    sel_mask_o = masks_i[port_i];
    // unicast bypasses the VLAN mask unless enforcement is on
    allow      = (mcast_i || enf_i) ? sel_mask_o : '1;
    self_bit   = NUM_PORTS'(1) << port_i;
    dest_o     = dest_i & allow & ~self_bit;
  end
endmodule

// File: rtl/vlan_egress_filter.sv
module vlan_egress_filter #(
  parameter int unsigned NUM_PORTS = vlan_filt_pkg::NUM_PORTS,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_mask_we_i,
  input  logic [PORT_W-1:0]    cfg_port_i,
  input  logic [NUM_PORTS-1:0] cfg_mask_i,
  input  logic                 cfg_enf_we_i,
  input  logic                 cfg_enf_i,
  input  logic                 req_valid_i,
  input  logic [PORT_W-1:0]    req_port_i,
  input  logic [NUM_PORTS-1:0] req_dest_i,
  input  logic                 req_mcast_i,
  output logic                 rsp_valid_o,
  output logic [NUM_PORTS-1:0] rsp_dest_o
);
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks;
  logic                                enf;
  logic [NUM_PORTS-1:0]                sel_mask;
  logic [NUM_PORTS-1:0]                filt_dest;
  logic                                valid_q;
  logic [NUM_PORTS-1:0]                dest_q;

  vlan_mask_store #(.NUM_PORTS(NUM_PORTS)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (cfg_mask_we_i),
    .mask_port_i (cfg_port_i),
    .mask_i      (cfg_mask_i),
    .enf_we_i    (cfg_enf_we_i),
    .enf_i       (cfg_enf_i),
    .masks_o     (masks),
    .enf_o       (enf)
  );

  vlan_mask_apply #(.NUM_PORTS(NUM_PORTS)) u_apply (
    .masks_i    (masks),
    .enf_i      (enf),
    .port_i     (req_port_i),
    .dest_i     (req_dest_i),
    .mcast_i    (req_mcast_i),
    .sel_mask_o (sel_mask),
    .dest_o     (filt_dest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dest_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      dest_q  <= req_valid_i ? filt_dest : '0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_dest_o  = dest_q;
endmodule

// File: rtl/vlan_egress_filter_chk.sv
module vlan_egress_filter_chk #(
  parameter int unsigned NUM_PORTS = vlan_filt_pkg::NUM_PORTS,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [PORT_W-1:0]    req_port_i,
  input logic [NUM_PORTS-1:0] req_dest_i,
  input logic                 req_mcast_i,
  input logic                 enf,
  input logic [NUM_PORTS-1:0] sel_mask,
  input logic                 rsp_valid_o,
  input logic [NUM_PORTS-1:0] rsp_dest_o
);
  logic [NUM_PORTS-1:0] self_oh;
  assign self_oh = NUM_PORTS'(1) << req_port_i;

  p_valid_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rsp_dest_o == '0);
  p_mcast_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mcast_i) |=> (rsp_dest_o & ~$past(sel_mask)) == '0);
  p_ucast_enf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_mcast_i && enf) |=> (rsp_dest_o & ~$past(sel_mask)) == '0);
  p_ucast_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_mcast_i && !enf) |=>
      rsp_dest_o == ($past(req_dest_i) & ~$past(self_oh)));
  p_self_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_dest_o & $past(self_oh)) == '0);
  p_subset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_dest_o & ~$past(req_dest_i)) == '0);
endmodule

bind vlan_egress_filter vlan_egress_filter_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_port_i  (req_port_i),
  .req_dest_i  (req_dest_i),
  .req_mcast_i (req_mcast_i),
  .enf         (enf),
  .sel_mask    (sel_mask),
  .rsp_valid_o (rsp_valid_o),
  .rsp_dest_o  (rsp_dest_o)
);

// File: tb/vlan_egress_filter_test.sv
module vlan_egress_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int PW = 3;
  localparam int NVEC = 10;
  // {port[11:9], mcast[8], dest[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 8'hFF}, {3'd7, 1'b1, 8'hFF}, {3'd3, 1'b0, 8'h81},
    {3'd7, 1'b0, 8'hF0}, {3'd2, 1'b1, 8'h0F}, {3'd5, 1'b0, 8'h20},
    {3'd6, 1'b1, 8'hC0}, {3'd1, 1'b0, 8'h7E}, {3'd4, 1'b1, 8'h90},
    {3'd7, 1'b1, 8'h80}
  };

  logic clk = 0, rst_ni = 0;
  logic cfg_mask_we = 0, cfg_enf_we = 0, cfg_enf = 0;
  logic [PW-1:0] cfg_port = '0;
  logic [NP-1:0] cfg_mask = '0;
  logic req_valid = 0, req_mcast = 0;
  logic [PW-1:0] req_port = '0;
  logic [NP-1:0] req_dest = '0;
  logic rsp_valid;
  logic [NP-1:0] rsp_dest;

  logic [NP-1:0] sh_mask [NP];
  logic sh_enf;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_egress_filter uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_mask_we_i(cfg_mask_we), .cfg_port_i(cfg_port), .cfg_mask_i(cfg_mask),
    .cfg_enf_we_i(cfg_enf_we), .cfg_enf_i(cfg_enf),
    .req_valid_i(req_valid), .req_port_i(req_port), .req_dest_i(req_dest),
    .req_mcast_i(req_mcast), .rsp_valid_o(rsp_valid), .rsp_dest_o(rsp_dest)
  );

  function automatic logic [NP-1:0] model(input logic [PW-1:0] p, input logic mc,
                                          input logic [NP-1:0] d);
    logic [NP-1:0] r;
    r = d & ((mc || sh_enf) ? sh_mask[p] : 8'hFF);
    r[p] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic v, input logic [NP-1:0] d,
                       input logic ev, input logic [NP-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      fails++;
      $display("FAIL %s: got valid=%0b dest=%02h, expected valid=%0b dest=%02h",
               req, v, d, ev, ed);
    end
  endtask

  task automatic wr_mask(input int p, input logic [NP-1:0] m);
    @(negedge clk);
    cfg_mask_we = 1; cfg_port = PW'(p); cfg_mask = m;
    @(negedge clk);
    cfg_mask_we = 0;
    sh_mask[p] = m;
  endtask

  task automatic wr_enf(input logic e);
    @(negedge clk);
    cfg_enf_we = 1; cfg_enf = e;
    @(negedge clk);
    cfg_enf_we = 0;
    sh_enf = e;
  endtask

  task automatic do_req(input string req, input logic [PW-1:0] p, input logic mc,
                        input logic [NP-1:0] d);
    logic [NP-1:0] exp_d;
    exp_d = model(p, mc, d);
    @(negedge clk);
    req_valid = 1; req_port = p; req_mcast = mc; req_dest = d;
    @(negedge clk);
    req_valid = 0;
    check(req, rsp_valid, rsp_dest, 1'b1, exp_d);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) sh_mask[i] = 8'hFF;
    sh_enf = 0;
    #(CLK_PERIOD * 2 + 1);
    check("R1 reset", rsp_valid, rsp_dest, 1'b0, 8'h00);
    rst_ni = 1;
    // R1/R6: default masks open, enforcement clear
    do_req("R1 default mcast", 3'd2, 1'b1, 8'hFF);
    check("R1 default value", rsp_valid, rsp_dest, 1'b1, 8'hFB);
    do_req("R1 default ucast", 3'd5, 1'b0, 8'hFF);
    @(negedge clk);
    check("R2 idle", rsp_valid, rsp_dest, 1'b0, 8'h00);

    // hub at index 7, leaves see only hub (asymmetric, R8/R10)
    for (int p = 0; p < NP - 1; p++) wr_mask(p, 8'h80);
    wr_mask(7, 8'h7F);
    for (int pass = 0; pass < 2; pass++) begin
      wr_enf(pass[0]);
      for (int i = 0; i < NVEC; i++)
        do_req(VEC[i][8] ? "R3 mcast vec" : (pass == 0 ? "R5 ucast open vec" : "R4 ucast enf vec"),
               VEC[i][11:9], VEC[i][8], VEC[i][7:0]);
    end
    // R4 explicit: leaf unicast toward leaf is dropped under enforcement
    do_req("R4 ucast blocked", 3'd1, 1'b0, 8'h08);
    check("R4 ucast blocked value", rsp_valid, rsp_dest, 1'b1, 8'h00);
    // R7: empty result still valid
    do_req("R7 empty mcast", 3'd0, 1'b1, 8'h02);
    check("R7 empty value", rsp_valid, rsp_dest, 1'b1, 8'h00);
    // R6: self only requested
    do_req("R6 self only", 3'd7, 1'b1, 8'h80);
    check("R6 self value", rsp_valid, rsp_dest, 1'b1, 8'h00);
    // R8: change port 2 only, port 3 unchanged
    wr_mask(2, 8'h0B);
    do_req("R8 port2 new", 3'd2, 1'b1, 8'hFF);
    check("R8 port2 value", rsp_valid, rsp_dest, 1'b1, 8'h0B);
    do_req("R8 port3 kept", 3'd3, 1'b1, 8'hFF);
    check("R8 port3 value", rsp_valid, rsp_dest, 1'b1, 8'h80);
    // R10: single-bit mask maps bit n to port n
    wr_mask(4, 8'h01);
    do_req("R10 bit0", 3'd4, 1'b1, 8'hFF);
    check("R10 bit0 value", rsp_valid, rsp_dest, 1'b1, 8'h01);
    // R9: write and request in same cycle, old mask applies
    @(negedge clk);
    cfg_mask_we = 1; cfg_port = 3'd0; cfg_mask = 8'h7E;
    req_valid = 1; req_port = 3'd0; req_mcast = 1; req_dest = 8'hFF;
    @(negedge clk);
    cfg_mask_we = 0; req_valid = 0;
    check("R9 old mask", rsp_valid, rsp_dest, 1'b1, 8'h80);
    sh_mask[0] = 8'h7E;
    do_req("R9 new mask", 3'd0, 1'b1, 8'hFF);
    check("R9 new value", rsp_valid, rsp_dest, 1'b1, 8'h7E);
    @(negedge clk);
    check("R2 idle after", rsp_valid, rsp_dest, 1'b0, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule